// File: doc/BRIEF.md
# Double-Buffered Audio User-Bit Capture

This block collects the user bit carried in every subframe of a two-channel professional digital audio stream and assembles a full block of them, 192 frames by default. Each frame gives one bit for channel A and one for channel B. The incoming bits land in a capture store. When the next block-start marker shows that the previous block was complete, the whole capture store is copied in one cycle into a second, read-only store. A single-cycle `block_ready` pulse marks the copy. The reader never sees the capture store.

The read side is a synchronous register-style port. A byte address can be loaded, or an internal pointer can step automatically by one two-byte word per read, so a whole block can be fetched as one burst. Every read returns a 16-bit word in which the A and B bits alternate pair by pair, and the earliest-received bit sits in the most significant position. While the reader holds `rd_burst` high, a due copy is held back, so one burst never mixes two blocks. The upstream frame decoder drives the subframe strobes, and a control-port front end drives the read side.

Top module: `ubit_block_capture`

## Requirements
- R1: After reset, `block_ready` and `rd_valid` are low, and every word read from the readable store is 0.
- R2: Word w holds the bits of frames 8w to 8w+7. Bit 15-2j holds the A bit of frame 8w+j, and bit 14-2j holds the B bit of frame 8w+j, for j = 0..7. Bit 15 is therefore the earliest A bit of the word and bit 0 the latest B bit.
- R3: A byte address a selects word a>>1. The pair of bytes 2w, 2w+1 is word w, so the first bytes read are the first bits captured. An odd address reads the same word as the even address below it. Load addresses of 48 or more read 0.
- R4: Each cycle with `rd_en` high produces exactly one word, with `rd_valid` high in the next cycle. `rd_valid` is low after any cycle without `rd_en`.
- R5: A read with `rd_load` high uses `rd_addr`. A read with `rd_load` low uses the internal pointer. Every read sets the pointer to the effective address rounded down to even plus 2, and wraps it to 0 after the last word (bytes 46 and 47).
- R6: A block-start subframe arriving after 192 complete frames (an A and a B bit each) copies that block into the readable store. `block_ready` is then high for exactly the one cycle after the start strobe.
- R7: A block-start subframe arriving before 192 frames are complete discards the partial block and restarts capture at frame 0. No copy is made, the readable store is unchanged, and `block_ready` stays low. This includes the first block start after reset.
- R8: If the copy falls due while `rd_burst` is high, it is held back until the first cycle in which `rd_burst` is low. `block_ready` rises in the cycle after that one, and the readable store does not change while `rd_burst` is high.
- R9: While a held-back copy is pending, all subframes, block starts included, are ignored. After the copy, capture stays idle until the next block start, so a full block without a start marker produces no copy.
- R10: Subframes received after 192 frames and before the next block start are ignored and do not alter the captured block.
- R11: Reads made while a block is being captured return the last copied block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One subframe's user bit is present this cycle |
| sf_ubit | input | 1 | User bit of the subframe |
| sf_is_b | input | 1 | 0 = channel A subframe, 1 = channel B subframe |
| sf_blk_start | input | 1 | Subframe is the channel A subframe of frame 0 of a block |
| rd_en | input | 1 | Read one word this cycle |
| rd_load | input | 1 | Use `rd_addr` instead of the internal pointer |
| rd_addr | input | 6 | Byte address for loaded reads |
| rd_burst | input | 1 | Reader is inside a multi-word burst; copies wait |
| rd_valid | output | 1 | `rd_data` holds a word requested the cycle before |
| rd_data | output | 16 | Interleaved A/B word |
| block_ready | output | 1 | One-cycle pulse after a block has been copied |

## Verification
The bench fills blocks with single-bit markers, so a design that swapped the A and B lanes, reversed the order within a byte or shifted words would put the marker on the wrong bit. It reads across the end of a block, where a pointer that does not wrap would walk into empty addresses. It cuts a block short and checks that the readable store keeps the older block, which catches a design that copied partial data. It holds a burst open over a block boundary, feeds subframes and a start marker into the pending window, and then sends a full unmarked block afterwards. A design that copied early, let the pending window overwrite the held block, or resumed capture without a start marker would then deliver the wrong words or raise an extra `block_ready`.

// File: rtl/ubit_pkg.sv
package ubit_pkg;
   localparam int UB_WORD_W = 16;
   localparam int UB_BITS_PER_LANE = UB_WORD_W / 2;

   typedef logic [UB_WORD_W-1:0] ub_word_t;

   function automatic int ub_bytes(input int frames);
      return (2 * frames) / 8;
   endfunction

   function automatic int ub_words(input int frames);
      return frames / UB_BITS_PER_LANE;
   endfunction
endpackage

// File: rtl/ubit_fill_ctrl.sv
module ubit_fill_ctrl #(
   parameter int FRAMES = 192,
   localparam int CNT_W = $clog2(FRAMES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sf_valid,
   input  logic              sf_ubit,
   input  logic              sf_is_b,
   input  logic              sf_blk_start,
   input  logic              hold,
   input  logic              rd_burst,
   output logic              done_now,
   output logic [FRAMES-1:0] fill_a,
   output logic [FRAMES-1:0] fill_b
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAMES);

   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             accept;
   logic             park;

   always_comb begin
      accept   = sf_valid & ~hold;
      done_now = accept & sf_blk_start & run & (cnt == FULL_CNT);
      park     = done_now & rd_burst;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         run    <= 1'b0;
         fill_a <= '0;
         fill_b <= '0;
      end else if (accept) begin
         if (sf_blk_start) begin
            if (park) begin
               // keep the finished block intact until it is copied
               run <= 1'b0;
               cnt <= '0;
            end else begin
               run <= 1'b1;
               if (sf_is_b) begin
                  fill_b[0] <= sf_ubit;
                  cnt       <= CNT_W'(1);
               end else begin
                  fill_a[0] <= sf_ubit;
                  cnt       <= '0;
               end
            end
         end else if (run && cnt < FULL_CNT) begin
            if (sf_is_b) begin
               fill_b[cnt] <= sf_ubit;
               cnt         <= cnt + CNT_W'(1);
            end else begin
               fill_a[cnt] <= sf_ubit;
            end
         end
      end
   end
endmodule

// File: rtl/ubit_xfer_ctrl.sv
module ubit_xfer_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic done_now,
   input  logic rd_burst,
   output logic pending,
   output logic copy_en,
   output logic block_ready
);
   always_comb begin
      copy_en = (done_now | pending) & ~rd_burst;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending     <= 1'b0;
         block_ready <= 1'b0;
      end else begin
         block_ready <= copy_en;
         if (pending) pending <= rd_burst;
         else         pending <= done_now & rd_burst;
      end
   end
endmodule

// File: rtl/ubit_shadow_rd.sv
module ubit_shadow_rd
   import ubit_pkg::*;
#(
   parameter int FRAMES = 192,
   localparam int BYTES = ub_bytes(FRAMES),
   localparam int WORDS = ub_words(FRAMES),
   localparam int AW    = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              copy_en,
   input  logic [FRAMES-1:0] fill_a,
   input  logic [FRAMES-1:0] fill_b,
   input  logic              rd_en,
   input  logic              rd_load,
   input  logic [AW-1:0]     rd_addr,
   output logic [FRAMES-1:0] sh_a,
   output logic [FRAMES-1:0] sh_b,
   output logic              rd_valid,
   output ub_word_t          rd_data
);
   localparam logic [AW-1:0] LAST_PAIR = AW'(BYTES - 2);
   localparam int            LANE      = UB_BITS_PER_LANE;

   logic [AW-1:0]   ptr;
   logic [AW-1:0]   eff;
   logic [AW-2:0]   widx;
   logic [LANE-1:0] a_sel;
   logic [LANE-1:0] b_sel;
   ub_word_t        word_nx;

   always_comb begin
      eff   = rd_load ? rd_addr : ptr;
      widx  = eff[AW-1:1];
      a_sel = '0;
      b_sel = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (widx == (AW-1)'(w)) begin
            a_sel = sh_a[w*LANE +: LANE];
            b_sel = sh_b[w*LANE +: LANE];
         end
      end
   end

   // earliest bit of each lane lands in the upper half of its pair
   for (genvar j = 0; j < LANE; j++) begin : g_weave
      assign word_nx[UB_WORD_W-1-2*j] = a_sel[j];
      assign word_nx[UB_WORD_W-2-2*j] = b_sel[j];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_a     <= '0;
         sh_b     <= '0;
         ptr      <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (copy_en) begin
            sh_a <= fill_a;
            sh_b <= fill_b;
         end
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= word_nx;
            ptr     <= (eff >= LAST_PAIR) ? '0 : ({eff[AW-1:1], 1'b0} + AW'(2));
         end
      end
   end
endmodule

// File: rtl/ubit_block_capture.sv
module ubit_block_capture
   import ubit_pkg::*;
#(
   parameter int FRAMES = 192,
   localparam int BYTES = ub_bytes(FRAMES),
   localparam int AW    = $clog2(BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sf_valid,
   input  logic                 sf_ubit,
   input  logic                 sf_is_b,
   input  logic                 sf_blk_start,
   input  logic                 rd_en,
   input  logic                 rd_load,
   input  logic [AW-1:0]        rd_addr,
   input  logic                 rd_burst,
   output logic                 rd_valid,
   output logic [UB_WORD_W-1:0] rd_data,
   output logic                 block_ready
);
   if (FRAMES < UB_BITS_PER_LANE || (FRAMES % UB_BITS_PER_LANE) != 0) begin : g_bad_frames
      $error("FRAMES must be a positive multiple of 8");
   end

   logic              done_now;
   logic              pending;
   logic              copy_en;
   logic [FRAMES-1:0] fill_a;
   logic [FRAMES-1:0] fill_b;
   logic [FRAMES-1:0] shadow_a;
   logic [FRAMES-1:0] shadow_b;

   ubit_fill_ctrl #(.FRAMES(FRAMES)) u_fill (
      .clk          (clk),
      .rst_n        (rst_n),
      .sf_valid     (sf_valid),
      .sf_ubit      (sf_ubit),
      .sf_is_b      (sf_is_b),
      .sf_blk_start (sf_blk_start),
      .hold         (pending),
      .rd_burst     (rd_burst),
      .done_now     (done_now),
      .fill_a       (fill_a),
      .fill_b       (fill_b)
   );

   ubit_xfer_ctrl u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_now    (done_now),
      .rd_burst    (rd_burst),
      .pending     (pending),
      .copy_en     (copy_en),
      .block_ready (block_ready)
   );

   ubit_shadow_rd #(.FRAMES(FRAMES)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .copy_en  (copy_en),
      .fill_a   (fill_a),
      .fill_b   (fill_b),
      .rd_en    (rd_en),
      .rd_load  (rd_load),
      .rd_addr  (rd_addr),
      .sh_a     (shadow_a),
      .sh_b     (shadow_b),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/ubit_capture_chk.sv
module ubit_capture_chk #(
   parameter int FRAMES = 192
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rd_valid,
   input logic              rd_burst,
   input logic              block_ready,
   input logic [FRAMES-1:0] sh_a,
   input logic [FRAMES-1:0] sh_b
);
   p_ready_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      block_ready |=> !block_ready);

   p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   p_ready_after_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      block_ready |-> !$past(rd_burst));

   p_store_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_burst) |-> ($stable(sh_a) && $stable(sh_b)));
endmodule

bind ubit_block_capture ubit_capture_chk #(.FRAMES(FRAMES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .rd_burst    (rd_burst),
   .block_ready (block_ready),
   .sh_a        (shadow_a),
   .sh_b        (shadow_b)
);

// File: tb/tb_ubit_block_capture.sv
module tb_ubit_block_capture;
   localparam int FRAMES = 192;
   localparam int WORDS  = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sf_valid = 1'b0, sf_ubit = 1'b0, sf_is_b = 1'b0, sf_blk_start = 1'b0;
   logic        rd_en = 1'b0, rd_load = 1'b0, rd_burst = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic        rd_valid, block_ready;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   int ready_seen = 0;
   bit mA [FRAMES];
   bit mB [FRAMES];
   logic [15:0] q_exp [$];
   string       q_tag [$];

   always #2 clk = ~clk;

   ubit_block_capture dut (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_ubit(sf_ubit),
      .sf_is_b(sf_is_b), .sf_blk_start(sf_blk_start), .rd_en(rd_en),
      .rd_load(rd_load), .rd_addr(rd_addr), .rd_burst(rd_burst),
      .rd_valid(rd_valid), .rd_data(rd_data), .block_ready(block_ready)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit patt(int k, int i, int ch);
      logic [15:0] v;
      if (k == 0) return (ch == 0) ? (i == 0) : (i == 9);
      v = 16'(i * 37 + k * 101 + ch * 59);
      return ^v[7:0];
   endfunction

   function automatic logic [15:0] expw(int w);
      logic [15:0] e;
      for (int j = 0; j < 8; j++) begin
         e[15-2*j] = mA[8*w+j];
         e[14-2*j] = mB[8*w+j];
      end
      return e;
   endfunction

   task automatic set_model(int k);
      for (int i = 0; i < FRAMES; i++) begin
         mA[i] = patt(k, i, 0);
         mB[i] = patt(k, i, 1);
      end
   endtask

   task automatic sf(bit u, bit b, bit s);
      sf_valid = 1'b1; sf_ubit = u; sf_is_b = b; sf_blk_start = s;
      @(negedge clk);
      sf_valid = 1'b0; sf_blk_start = 1'b0;
   endtask

   task automatic send_frames(int k, int first, int n, bit start_first);
      for (int i = first; i < first + n; i++) begin
         sf(patt(k, i, 0), 1'b0, start_first && (i == first));
         sf(patt(k, i, 1), 1'b1, 1'b0);
      end
   endtask

   task automatic rd(bit load, logic [5:0] addr, logic [15:0] exp, string tag);
      rd_en = 1'b1; rd_load = load; rd_addr = addr;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0; rd_load = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (block_ready) ready_seen++;
         if (rd_valid) begin
            if (q_exp.size() == 0) chk("R4 unexpected word", 1, 0);
            else chk(q_tag.pop_front(), 32'(rd_data), 32'(q_exp.pop_front()));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", 32'(block_ready), 0);
      chk("R1 valid", 32'(rd_valid), 0);
      rd(1'b1, 6'd0, 16'h0000, "R1");
      rd(1'b1, 6'd46, 16'h0000, "R1");

      // first block: start with nothing captured gives no copy
      send_frames(0, 0, FRAMES, 1'b1);
      chk("R7 first start", 32'(ready_seen), 0);

      sf(patt(1, 0, 0), 1'b0, 1'b1);
      chk("R6 ready high", 32'(block_ready), 1);
      set_model(0);
      sf(patt(1, 0, 1), 1'b1, 1'b0);
      chk("R6 ready pulse ends", 32'(block_ready), 0);
      rd(1'b1, 6'd0, 16'h8000, "R2");
      rd(1'b1, 6'd2, 16'h1000, "R2");
      rd(1'b1, 6'd4, 16'h0000, "R2");
      send_frames(1, 1, FRAMES - 1, 1'b0);

      sf(patt(2, 0, 0), 1'b0, 1'b1);
      set_model(1);
      sf(patt(2, 0, 1), 1'b1, 1'b0);
      send_frames(2, 1, 100, 1'b0);
      rd(1'b1, 6'd0, expw(0), "R5");
      for (int w = 1; w < WORDS; w++) rd(1'b0, 6'd0, expw(w), "R5");
      rd(1'b0, 6'd0, expw(0), "R5 wrap");
      rd(1'b1, 6'd20, expw(10), "R11");
      rd(1'b1, 6'd21, expw(10), "R3 odd");
      rd(1'b1, 6'd46, expw(23), "R3 last");
      rd(1'b1, 6'd50, 16'h0000, "R3 out of range");
      send_frames(2, 101, FRAMES - 101, 1'b0);

      // partial block is dropped
      sf(patt(3, 0, 0), 1'b0, 1'b1);
      set_model(2);
      sf(patt(3, 0, 1), 1'b1, 1'b0);
      send_frames(3, 1, 49, 1'b0);
      r0 = ready_seen;
      sf(patt(4, 0, 0), 1'b0, 1'b1);
      sf(patt(4, 0, 1), 1'b1, 1'b0);
      chk("R7 no copy", 32'(ready_seen), 32'(r0));
      rd(1'b1, 6'd0, expw(0), "R7");
      rd(1'b1, 6'd30, expw(15), "R7");
      send_frames(4, 1, FRAMES - 1, 1'b0);
      send_frames(9, 0, 5, 1'b0);

      // copy held back by an open burst
      rd_burst = 1'b1;
      sf(patt(5, 0, 0), 1'b0, 1'b1);
      chk("R8 held", 32'(block_ready), 0);
      rd(1'b1, 6'd0, expw(0), "R8");
      rd(1'b0, 6'd0, expw(1), "R8");
      send_frames(5, 0, 20, 1'b0);
      sf(patt(5, 0, 0), 1'b0, 1'b1);
      chk("R9 start while pending", 32'(block_ready), 0);
      rd(1'b1, 6'd0, expw(0), "R8 store frozen");
      rd_burst = 1'b0;
      @(negedge clk);
      chk("R8 released", 32'(block_ready), 1);
      set_model(4);
      @(negedge clk);
      chk("R8 pulse ends", 32'(block_ready), 0);
      rd(1'b1, 6'd0, expw(0), "R8");
      for (int w = 1; w < WORDS; w++) rd(1'b0, 6'd0, expw(w), "R10");

      // capture idles until a start marker
      r0 = ready_seen;
      send_frames(8, 0, FRAMES, 1'b0);
      sf(patt(6, 0, 0), 1'b0, 1'b1);
      @(negedge clk);
      chk("R9 unmarked block", 32'(ready_seen), 32'(r0));
      sf(patt(6, 0, 1), 1'b1, 1'b0);
      send_frames(6, 1, FRAMES - 1, 1'b0);
      sf(patt(7, 0, 0), 1'b0, 1'b1);
      chk("R6 ready after resume", 32'(block_ready), 1);
      set_model(6);
      rd(1'b1, 6'd0, expw(0), "R6");
      rd(1'b1, 6'd22, expw(11), "R6");
      rd(1'b1, 6'd46, expw(23), "R6");
      @(negedge clk);
      chk("R4 all words returned", 32'(q_exp.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule